// File: doc/BRIEF.md
# Secure Coprocessor Access Controller

This block holds the two registers that decide whether coprocessor instructions may run. The first is a coprocessor permission register, with one 2-bit field for each coprocessor. The second is a non-secure grant register, with one bit for each of the coprocessors 0 to 13. The grant register controls what the non-secure world may change and use.

The controller has two request ports. A register port carries reads and writes, each tagged with a privilege level and a security state. A check port asks whether a coprocessor instruction may run, and is tagged with the coprocessor number, the security state and a privileged flag. Each port answers one cycle after its request. A register answer carries acknowledge, undefined and read data. A check answer carries accept or undefined.

Parameters select whether the security extension is present, whether the two floating-point coprocessors (10 and 11) exist, and which other coprocessors are implemented.

Top module: `cpgate_ctrl`

## Requirements
- R1: The grant register holds bits [13:0] of a write, one bit per coprocessor n; a read returns it zero-extended, so bits [31:14] are 0. Both registers reset to 0.
- R2: `reg_sel_i`=1 addresses the grant register. Level 3 (`reg_pl_i`=3) may read and write it. Levels 1 and 2 may only read it. Level 0 gets undefined. A write below level 3 raises undefined and leaves the register unchanged. Without the security extension, every access to the grant register is undefined.
- R3: `reg_sel_i`=0 addresses the permission register. Levels 1 to 3 may read and write it. A level 0 access raises undefined and changes nothing.
- R4: In the permission register, coprocessor n owns bits [2n+1:2n]. A write stores only the fields of implemented coprocessors. Fields of unimplemented coprocessors, and bits [31:28], always read 0. Coprocessors 10 and 11 count as implemented when the floating-point option is set.
- R5: With the security extension present, a non-secure write (`reg_ns_i`=1) to the permission register updates only the fields whose grant bit is 1. Every other field keeps its value.
- R6: A secure write, or any write when the security extension is absent, updates all implemented fields, whatever the grant register holds.
- R7: With the security extension present, a non-secure check on coprocessor n whose grant bit is 0 returns undefined, whatever its permission field holds. Secure checks, and all checks when the extension is absent, ignore the grant register.
- R8: Permission field codes: 00 denies, 01 accepts only privileged checks (`chk_priv_i`=1), 11 accepts all, and 10 denies. A denial returns undefined.
- R9: Each response is valid exactly one cycle after its request. Accept and undefined are mutually exclusive, and so are acknowledge and undefined. A check sees the register contents from before any write accepted in the same cycle.
- R10: A check on coprocessor 14 or 15 returns undefined.
- R11: While in reset, every response output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_req_i | input | 1 | Register access request |
| reg_sel_i | input | 1 | 0 = permission register, 1 = grant register |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_pl_i | input | 2 | Privilege level 0..3 (3 = monitor) |
| reg_ns_i | input | 1 | Access is non-secure |
| reg_wdata_i | input | 32 | Write data |
| reg_rsp_valid_o | output | 1 | Register response valid |
| reg_ack_o | output | 1 | Access performed |
| reg_undef_o | output | 1 | Access rejected as undefined |
| reg_rdata_o | output | 32 | Read data (0 unless an acknowledged read) |
| chk_req_i | input | 1 | Coprocessor check request |
| chk_cp_i | input | 4 | Coprocessor number |
| chk_ns_i | input | 1 | Instruction runs non-secure |
| chk_priv_i | input | 1 | Instruction runs privileged |
| chk_rsp_valid_o | output | 1 | Check response valid |
| chk_accept_o | output | 1 | Instruction allowed |
| chk_undef_o | output | 1 | Instruction undefined |

## Verification
The bench targets non-secure permission writes made under a partial grant mask. If the merge were done wrongly, fields that belong to the secure world would be cleared, or the write would be dropped entirely.

It also exercises the reserved code 10 and the privileged-only code 01. A decoder that tested a single bit would accept the reserved code, and one that ignored privilege would let unprivileged code through.

Kernel-level writes to the grant register are issued and then read back. A design that checked privilege only for reads would silently change the register.

Finally, a check is issued in the same cycle as the write that changes its field. This exposes forwarding of the new value. A second instance without the security extension or floating point confirms that gating and masking disappear there.

// File: rtl/cpgate_pkg.sv
package cpgate_pkg;

    // privilege levels on the register port
    localparam logic [1:0] PL_USER = 2'd0;
    localparam logic [1:0] PL_KERN = 2'd1;
    localparam logic [1:0] PL_HYP  = 2'd2;
    localparam logic [1:0] PL_MON  = 2'd3;

    // permission field codes
    localparam logic [1:0] FLD_DENY = 2'b00;
    localparam logic [1:0] FLD_PRIV = 2'b01;
    localparam logic [1:0] FLD_RSVD = 2'b10;
    localparam logic [1:0] FLD_FULL = 2'b11;

    // register selector
    localparam logic SEL_PERM  = 1'b0;
    localparam logic SEL_GRANT = 1'b1;

    typedef struct packed {
        logic valid;
        logic accept;
        logic undef;
    } chk_rsp_t;

endpackage

// File: rtl/cpgate_regs.sv
module cpgate_regs
    import cpgate_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          NCP     = 14,
    parameter bit          HAS_SEC = 1'b1,
    parameter bit          HAS_FP  = 1'b1,
    parameter logic [13:0] IMPL_CP = 14'h0003,
    parameter int          FP_LO   = 10,
    parameter int          FP_HI   = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [1:0]        pl_i,
    input  logic              ns_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rsp_valid_o,
    output logic              ack_o,
    output logic              undef_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] perm_o,
    output logic [NCP-1:0]    grant_o
);

    localparam int FLD_BITS = 2 * NCP;

    typedef struct packed {
        logic [DATA_W-1:0] perm;
        logic [NCP-1:0]    grant;
        logic              valid;
        logic              ack;
        logic              undef;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic [DATA_W-1:0] impl_mask;
    logic [DATA_W-1:0] ns_mask;
    logic [DATA_W-1:0] perm_wr;

    for (genvar n = 0; n < NCP; n++) begin : g_fld
        localparam bit IMPL = IMPL_CP[n] || (HAS_FP && (n == FP_LO || n == FP_HI));
        assign impl_mask[2*n +: 2] = IMPL ? 2'b11 : 2'b00;
        assign ns_mask[2*n +: 2]   = {2{st_q.grant[n]}};
    end
    assign impl_mask[DATA_W-1:FLD_BITS] = '0;
    assign ns_mask[DATA_W-1:FLD_BITS]   = '0;

    always_comb begin
        perm_wr = wdata_i & impl_mask;
        if (HAS_SEC && ns_i) begin
            perm_wr = (perm_wr & ns_mask) | (st_q.perm & ~ns_mask);
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_i;
        st_d.ack   = 1'b0;
        st_d.undef = 1'b0;
        st_d.rdata = '0;
        if (req_i) begin
            if (sel_i == SEL_PERM) begin
                if (pl_i == PL_USER) begin
                    st_d.undef = 1'b1;
                end else if (wr_i) begin
                    st_d.perm = perm_wr;
                    st_d.ack  = 1'b1;
                end else begin
                    st_d.rdata = st_q.perm;
                    st_d.ack   = 1'b1;
                end
            end else begin
                if (!HAS_SEC || pl_i == PL_USER || (wr_i && pl_i != PL_MON)) begin
                    st_d.undef = 1'b1;
                end else if (wr_i) begin
                    st_d.grant = wdata_i[NCP-1:0];
                    st_d.ack   = 1'b1;
                end else begin
                    st_d.rdata = DATA_W'(st_q.grant);
                    st_d.ack   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.valid;
    assign ack_o       = st_q.ack;
    assign undef_o     = st_q.undef;
    assign rdata_o     = st_q.rdata;
    assign perm_o      = st_q.perm;
    assign grant_o     = st_q.grant;

    // R4
    unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (perm_o & ~impl_mask) == '0);

    // R1
    grant_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && sel_i == SEL_GRANT) |=> rdata_o[DATA_W-1:NCP] == '0);

    // R2
    grant_wr_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && wr_i && sel_i == SEL_GRANT && pl_i != PL_MON) |=> (undef_o && $stable(grant_o)));

    // R3
    perm_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && sel_i == SEL_PERM && pl_i == PL_USER) |=> (undef_o && $stable(perm_o)));

    if (HAS_SEC) begin : g_ns_chk
        // R5
        ns_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i && wr_i && ns_i && sel_i == SEL_PERM && pl_i != PL_USER)
            |=> ((perm_o ^ $past(perm_o)) & ~$past(ns_mask)) == '0);
    end

    // R9
    reg_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> (rsp_valid_o && (ack_o != undef_o)));

endmodule

// File: rtl/cpgate_check.sv
module cpgate_check
    import cpgate_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NCP     = 14,
    parameter int CP_W    = 4,
    parameter bit HAS_SEC = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [CP_W-1:0]   cp_i,
    input  logic              ns_i,
    input  logic              priv_i,
    input  logic [DATA_W-1:0] perm_i,
    input  logic [NCP-1:0]    grant_i,
    output logic              rsp_valid_o,
    output logic              accept_o,
    output logic              undef_o
);

    chk_rsp_t rsp_d, rsp_q;

    logic [1:0] fld;
    logic       granted;
    logic       in_range;
    logic       allow;

    always_comb begin
        fld      = FLD_DENY;
        granted  = 1'b0;
        in_range = 1'b0;
        for (int n = 0; n < NCP; n++) begin
            if (int'(cp_i) == n) begin
                fld      = perm_i[2*n +: 2];
                granted  = grant_i[n];
                in_range = 1'b1;
            end
        end
    end

    always_comb begin
        allow = 1'b0;
        if (in_range && !(HAS_SEC && ns_i && !granted)) begin
            case (fld)
                FLD_FULL: allow = 1'b1;
                FLD_PRIV: allow = priv_i;
                default:  allow = 1'b0;
            endcase
        end
        rsp_d.valid  = req_i;
        rsp_d.accept = req_i && allow;
        rsp_d.undef  = req_i && !allow;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign accept_o    = rsp_q.accept;
    assign undef_o     = rsp_q.undef;

    // R9
    chk_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> (rsp_valid_o && (accept_o != undef_o)));

    // R9
    chk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !(rsp_valid_o || accept_o || undef_o));

    // R10
    cp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && int'(cp_i) >= NCP) |=> undef_o);

    if (HAS_SEC) begin : g_gate_chk
        // R7
        ns_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i && ns_i && int'(cp_i) < NCP && ((grant_i >> cp_i) & NCP'(1)) == '0)
            |=> undef_o);
    end

endmodule

// File: rtl/cpgate_ctrl.sv
module cpgate_ctrl
    import cpgate_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          NCP     = 14,
    parameter bit          HAS_SEC = 1'b1,
    parameter bit          HAS_FP  = 1'b1,
    parameter logic [13:0] IMPL_CP = 14'h0003,
    localparam int         CP_W    = $clog2(NCP)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_req_i,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_pl_i,
    input  logic              reg_ns_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic              reg_rsp_valid_o,
    output logic              reg_ack_o,
    output logic              reg_undef_o,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              chk_req_i,
    input  logic [CP_W-1:0]   chk_cp_i,
    input  logic              chk_ns_i,
    input  logic              chk_priv_i,
    output logic              chk_rsp_valid_o,
    output logic              chk_accept_o,
    output logic              chk_undef_o
);

    logic [DATA_W-1:0] perm_q;
    logic [NCP-1:0]    grant_q;

    cpgate_regs #(
        .DATA_W (DATA_W),
        .NCP    (NCP),
        .HAS_SEC(HAS_SEC),
        .HAS_FP (HAS_FP),
        .IMPL_CP(IMPL_CP)
    ) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (reg_req_i),
        .sel_i      (reg_sel_i),
        .wr_i       (reg_wr_i),
        .pl_i       (reg_pl_i),
        .ns_i       (reg_ns_i),
        .wdata_i    (reg_wdata_i),
        .rsp_valid_o(reg_rsp_valid_o),
        .ack_o      (reg_ack_o),
        .undef_o    (reg_undef_o),
        .rdata_o    (reg_rdata_o),
        .perm_o     (perm_q),
        .grant_o    (grant_q)
    );

    cpgate_check #(
        .DATA_W (DATA_W),
        .NCP    (NCP),
        .CP_W   (CP_W),
        .HAS_SEC(HAS_SEC)
    ) check_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (chk_req_i),
        .cp_i       (chk_cp_i),
        .ns_i       (chk_ns_i),
        .priv_i     (chk_priv_i),
        .perm_i     (perm_q),
        .grant_i    (grant_q),
        .rsp_valid_o(chk_rsp_valid_o),
        .accept_o   (chk_accept_o),
        .undef_o    (chk_undef_o)
    );

endmodule

// File: tb/cpgate_ctrl_tb_top.sv
module cpgate_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0, reg_ns = 1'b0;
    logic [1:0]  reg_pl = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        chk_req = 1'b0, chk_ns = 1'b0, chk_priv = 1'b0;
    logic [3:0]  chk_cp = '0;

    logic        a_rv, a_ack, a_und, a_cv, a_acc, a_cu;
    logic [31:0] a_rd;
    logic        b_rv, b_ack, b_und, b_cv, b_acc, b_cu;
    logic [31:0] b_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench models
    logic [31:0] car_a = '0, car_b = '0;
    logic [13:0] nsp_a = '0, nsp_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpgate_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_req_i(reg_req), .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .reg_pl_i(reg_pl),
        .reg_ns_i(reg_ns), .reg_wdata_i(reg_wdata),
        .reg_rsp_valid_o(a_rv), .reg_ack_o(a_ack), .reg_undef_o(a_und), .reg_rdata_o(a_rd),
        .chk_req_i(chk_req), .chk_cp_i(chk_cp), .chk_ns_i(chk_ns), .chk_priv_i(chk_priv),
        .chk_rsp_valid_o(a_cv), .chk_accept_o(a_acc), .chk_undef_o(a_cu)
    );

    cpgate_ctrl #(.HAS_SEC(1'b0), .HAS_FP(1'b0)) dut_nosec_i (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_req_i(reg_req), .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .reg_pl_i(reg_pl),
        .reg_ns_i(reg_ns), .reg_wdata_i(reg_wdata),
        .reg_rsp_valid_o(b_rv), .reg_ack_o(b_ack), .reg_undef_o(b_und), .reg_rdata_o(b_rd),
        .chk_req_i(chk_req), .chk_cp_i(chk_cp), .chk_ns_i(chk_ns), .chk_priv_i(chk_priv),
        .chk_rsp_valid_o(b_cv), .chk_accept_o(b_acc), .chk_undef_o(b_cu)
    );

    function automatic logic [31:0] impl_mask(input bit has_fp);
        logic [31:0] m = '0;
        for (int n = 0; n < 14; n++) begin
            if (n < 2 || (has_fp && (n == 10 || n == 11))) m[2*n +: 2] = 2'b11;
        end
        return m;
    endfunction

    function automatic logic [31:0] spread(input logic [13:0] g);
        logic [31:0] m = '0;
        for (int n = 0; n < 14; n++) m[2*n +: 2] = {2{g[n]}};
        return m;
    endfunction

    function automatic void reg_model(input bit has_sec, input bit has_fp,
            input logic sel, input logic wr, input logic [1:0] pl, input logic ns,
            input logic [31:0] wd, inout logic [31:0] car, inout logic [13:0] nsp,
            output logic ack, output logic und, output logic [31:0] rd);
        logic [31:0] nm;
        ack = 1'b0; und = 1'b0; rd = '0;
        if (sel == 1'b0) begin
            if (pl == 2'd0) und = 1'b1;
            else begin
                ack = 1'b1;
                if (wr) begin
                    nm = spread(nsp);
                    if (has_sec && ns) car = (wd & impl_mask(has_fp) & nm) | (car & ~nm);
                    else car = wd & impl_mask(has_fp);
                end else rd = car;
            end
        end else begin
            if (!has_sec || pl == 2'd0 || (wr && pl != 2'd3)) und = 1'b1;
            else begin
                ack = 1'b1;
                if (wr) nsp = wd[13:0];
                else rd = {18'b0, nsp};
            end
        end
    endfunction

    function automatic logic chk_model(input bit has_sec, input logic [31:0] car,
            input logic [13:0] nsp, input logic [3:0] cp, input logic ns, input logic priv);
        logic [1:0] f;
        if (cp >= 4'd14) return 1'b0;
        if (has_sec && ns && !nsp[cp]) return 1'b0;
        f = car[2*cp +: 2];
        if (f == 2'b11) return 1'b1;
        if (f == 2'b01) return priv;
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle: drive requests, sample responses at the next falling edge
    task automatic step(input logic rv, input logic sel, input logic wr, input logic [1:0] pl,
                        input logic ns, input logic [31:0] wd, input logic cv,
                        input logic [3:0] cp, input logic cns, input logic cpriv,
                        input string tag);
        logic ea_ack, ea_und, eb_ack, eb_und, ea_acc, eb_acc;
        logic [31:0] ea_rd, eb_rd;
        reg_req = rv; reg_sel = sel; reg_wr = wr; reg_pl = pl; reg_ns = ns; reg_wdata = wd;
        chk_req = cv; chk_cp = cp; chk_ns = cns; chk_priv = cpriv;
        ea_acc = chk_model(1'b1, car_a, nsp_a, cp, cns, cpriv);
        eb_acc = chk_model(1'b0, car_b, nsp_b, cp, cns, cpriv);
        ea_ack = 0; ea_und = 0; ea_rd = '0; eb_ack = 0; eb_und = 0; eb_rd = '0;
        if (rv) begin
            reg_model(1'b1, 1'b1, sel, wr, pl, ns, wd, car_a, nsp_a, ea_ack, ea_und, ea_rd);
            reg_model(1'b0, 1'b0, sel, wr, pl, ns, wd, car_b, nsp_b, eb_ack, eb_und, eb_rd);
        end
        @(negedge clk);
        check(tag, "reg valid", {31'b0, a_rv}, {31'b0, rv});
        check(tag, "reg ack/undef", {30'b0, a_ack, a_und}, {30'b0, ea_ack, ea_und});
        check(tag, "reg rdata", a_rd, ea_rd);
        check(tag, "chk out", {29'b0, a_cv, a_acc, a_cu},
              {29'b0, cv, cv && ea_acc, cv && !ea_acc});
        check({tag, " R6"}, "nosec reg", {29'b0, b_ack, b_und, b_rv}, {29'b0, eb_ack, eb_und, rv});
        check({tag, " R6"}, "nosec rdata", b_rd, eb_rd);
        check({tag, " R7"}, "nosec chk", {30'b0, b_acc, b_cu}, {30'b0, cv && eb_acc, cv && !eb_acc});
        reg_req = 1'b0; chk_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset
        check("R11", "reset outputs", {26'b0, a_rv, a_ack, a_und, a_cv, a_acc, a_cu}, '0);
        check("R11", "reset rdata", a_rd, '0);
        rst_n = 1'b1;
        // R1: reset values and width
        step(1, 0, 0, 2'd3, 0, '0, 0, 0, 0, 0, "R1 perm reset");
        step(1, 1, 0, 2'd3, 0, '0, 0, 0, 0, 0, "R1 grant reset");
        step(1, 1, 1, 2'd3, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1 grant write");
        step(1, 1, 0, 2'd3, 0, '0, 0, 0, 0, 0, "R1 grant readback");
        // R2: kernel cannot write grant, can read it; user cannot read
        step(1, 1, 1, 2'd1, 0, 32'h0, 0, 0, 0, 0, "R2 kernel write");
        step(1, 1, 0, 2'd1, 0, '0, 0, 0, 0, 0, "R2 kernel read");
        step(1, 1, 0, 2'd0, 0, '0, 0, 0, 0, 0, "R2 user read");
        // R3: user write to perm ignored
        step(1, 0, 1, 2'd0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3 user write");
        step(1, 0, 0, 2'd1, 0, '0, 0, 0, 0, 0, "R3 readback");
        // R4 R6: secure write all ones
        step(1, 0, 1, 2'd1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R4 secure write");
        step(1, 0, 0, 2'd1, 0, '0, 0, 0, 0, 0, "R4 readback");
        // R5: grant cp0 and cp10 only, non-secure clear
        step(1, 1, 1, 2'd3, 0, 32'h0000_0401, 0, 0, 0, 0, "R5 grant setup");
        step(1, 0, 1, 2'd1, 1, 32'h0, 0, 0, 0, 0, "R5 ns write");
        step(1, 0, 0, 2'd1, 1, '0, 0, 0, 0, 0, "R5 readback");
        // R7: cp11 field 11, grant bit clear
        step(0, 0, 0, 0, 0, '0, 1, 4'd11, 1, 1, "R7 ns gated");
        step(0, 0, 0, 0, 0, '0, 1, 4'd11, 0, 1, "R7 secure ungated");
        // R8: cp0=11 cp1=01 cp10=10 cp11=11
        step(1, 0, 1, 2'd3, 0, 32'h00E0_0007, 0, 0, 0, 0, "R8 setup");
        step(0, 0, 0, 0, 0, '0, 1, 4'd0, 0, 0, "R8 full unpriv");
        step(0, 0, 0, 0, 0, '0, 1, 4'd1, 0, 1, "R8 priv-only priv");
        step(0, 0, 0, 0, 0, '0, 1, 4'd1, 0, 0, "R8 priv-only unpriv");
        step(0, 0, 0, 0, 0, '0, 1, 4'd10, 0, 1, "R8 reserved code");
        step(0, 0, 0, 0, 0, '0, 1, 4'd2, 0, 1, "R8 deny code");
        // R10
        step(0, 0, 0, 0, 0, '0, 1, 4'd14, 0, 1, "R10 cp14");
        step(0, 0, 0, 0, 0, '0, 1, 4'd15, 0, 1, "R10 cp15");
        // R9: same-cycle write and check sees old value
        step(1, 0, 1, 2'd3, 0, 32'h0000_000F, 1, 4'd1, 0, 0, "R9 same cycle");
        step(0, 0, 0, 0, 0, '0, 1, 4'd1, 0, 0, "R9 next cycle");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic rv, sel, wr, ns, cv, cns, cpr;
            logic [1:0] pl;
            logic [3:0] cp;
            logic [31:0] wd;
            string tag;
            rv = 1'($urandom); sel = ($urandom % 4) == 0; wr = 1'($urandom);
            pl = 2'($urandom); ns = 1'($urandom); wd = $urandom;
            cv = 1'($urandom); cns = 1'($urandom); cpr = 1'($urandom);
            cp = (($urandom % 3) == 0) ? 4'($urandom) : (1'($urandom) ? 4'd10 + 4'($urandom % 2) : 4'($urandom % 2));
            tag = !rv ? "R8 random" : (sel ? "R2 random" : (ns ? "R5 random" : "R3 random"));
            step(rv, sel, wr, pl, ns, wd, cv, cp, cns, cpr, tag);
        end
        // R9: idle after last request
        step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, "R9 idle");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule